// File: doc/BRIEF.md
# Interrupt Distributor State Register Bank

This block stores the per-interrupt control state of an interrupt distributor: an enable bit, a pending bit and an active bit for each line, an 8-bit CPU routing mask for each line, and a trigger-type bit for each line. Software reaches all of it through a flat 32-bit register port with a single-cycle write strobe and a combinational read. Every state bit has two write addresses, one that sets bits written as 1 and one that clears them, so software never has to read a word, modify it and write it back.

Hardware interrupt inputs feed the pending state. A line configured as rising-edge latches pending on a 0-to-1 transition of its input; a line configured as level-high shows pending while its input is high, in addition to any pending bit that software has set. The block drives one "ready to deliver" flag per line and the routing mask of every line; the arbitration and CPU-side logic that consume them are outside this block.

Top module: `irq_dist_bank`

## Requirements
- R1: After reset every enable, pending and active bit is 0, every routing byte is 0x01, lines 16 and up are level-type, and every `fire` bit is 0.
- R2: Writing `wdata` to 0x100 + 4*(n/32) with bit (n mod 32) set sets the enable bit of line n; the same write to 0x180 + 4*(n/32) clears it; 0 bits change nothing; reading either address returns the enable bits of that word.
- R3: Pending uses set address 0x200 + 4*(n/32) and clear address 0x280 + 4*(n/32) with the same bit layout, write-1 semantics and read-back as R2.
- R4: Active uses set address 0x300 + 4*(n/32) and clear address 0x380 + 4*(n/32) with the same bit layout, write-1 semantics and read-back as R2.
- R5: The routing mask of line n sits in the word at 0x800 + (n with its two low bits cleared), bits [8*(n mod 4)+7 : 8*(n mod 4)]; a write updates only the byte lanes whose `wstrb` bit is 1, leaving the other lanes of that word unchanged, and `target_mask[8n+7:8n]` shows the stored mask.
- R6: The trigger type of line n is bit 2*(n mod 16)+1 of the word at 0xC00 + 4*(n/16) (1 = rising edge, 0 = level-high; the lower bit of each pair reads 0); lines 0 to 15 always read as edge (word 0xC00 reads 0xAAAAAAAA) and ignore writes.
- R7: On an edge-type line, an input that was 0 in the previous cycle and is 1 now sets pending at the next clock; this holds even when a pending-clear write to that line arrives in the same cycle.
- R8: On a level-type line, pending reads as the software pending bit ORed with the current input level, and a software clear removes only the software part.
- R9: `fire[n]` is 1 exactly when line n reads pending, enabled and not active.
- R10: Bits of lines at or above N_IRQ and every address outside the groups above read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 12 | Byte address of the register word |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte-lane enables, used by routing writes |
| irq_in | input | N_IRQ | Hardware interrupt inputs |
| rdata | output | 32 | Combinational read data for `addr` |
| fire | output | N_IRQ | Per-line pending, enabled and not active |
| target_mask | output | 8*N_IRQ | Routing mask of each line, one byte per line |

## Verification
The bound checker watches line 0 on every cycle: set and clear aliases of the enable register take effect at the next edge, a disabled line stops firing, a rising edge outlasts a same-cycle pending clear, the software-generated configuration word always reads fixed, and the unused address window reads zero. Byte-lane preservation in the routing words, the level-versus-edge split of pending on lines 16 and up, read-back of unimplemented bits in a partial last word, and `fire` across all lines can only be shown by the bench's scenarios against its reference model.

// File: rtl/irq_dist_bank.sv
module irq_dist_bank #(
  parameter int N_IRQ = 48,
  parameter int N_SGI = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [11:0]        addr,
  input  logic [31:0]        wdata,
  input  logic [3:0]         wstrb,
  input  logic [N_IRQ-1:0]   irq_in,
  output logic [31:0]        rdata,
  output logic [N_IRQ-1:0]   fire,
  output logic [8*N_IRQ-1:0] target_mask
);
  logic [N_IRQ-1:0] en, pend_sw, act, trig_edge, in_q, pend_v;
  logic [7:0]       tgt [N_IRQ];

  wire in_state = addr[11:10] == 2'b00;
  wire in_tgt   = addr[11:10] == 2'b10;
  wire in_cfg   = addr[11:10] == 2'b11;

  assign pend_v = pend_sw | (~trig_edge & irq_in);
  assign fire   = pend_v & en & ~act;

  always_ff @(posedge clk) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= irq_in;
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    localparam int W = i / 32;
    localparam int B = i % 32;
    localparam int L = i % 4;
    wire hit  = wr_en && in_state && addr[6:2] == 5'(W) && wdata[B];
    wire rise = trig_edge[i] && irq_in[i] && !in_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en[i]      <= 1'b0;
        pend_sw[i] <= 1'b0;
        act[i]     <= 1'b0;
      end else begin
        if (hit && addr[9:7] == 3'b010) en[i] <= 1'b1;
        if (hit && addr[9:7] == 3'b011) en[i] <= 1'b0;
        if (hit && addr[9:7] == 3'b100) pend_sw[i] <= 1'b1;
        if (hit && addr[9:7] == 3'b101) pend_sw[i] <= 1'b0;
        if (rise)                       pend_sw[i] <= 1'b1;
        if (hit && addr[9:7] == 3'b110) act[i] <= 1'b1;
        if (hit && addr[9:7] == 3'b111) act[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) tgt[i] <= 8'h01;
      else if (wr_en && in_tgt && addr[9:2] == 8'(i / 4) && wstrb[L])
        tgt[i] <= wdata[8*L +: 8];
    end
    assign target_mask[8*i +: 8] = tgt[i];

    if (i < N_SGI) begin : g_fixed
      assign trig_edge[i] = 1'b1;
    end else begin : g_cfg
      always_ff @(posedge clk) begin
        if (!rst_n) trig_edge[i] <= 1'b0;
        else if (wr_en && in_cfg && addr[9:2] == 8'(i / 16))
          trig_edge[i] <= wdata[2*(i % 16) + 1];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (in_state && addr[6:2] == 5'(i / 32)) begin
        case (addr[9:8])
          2'b01:   rdata[i % 32] = en[i];
          2'b10:   rdata[i % 32] = pend_v[i];
          2'b11:   rdata[i % 32] = act[i];
          default: ;
        endcase
      end
      if (in_tgt && addr[9:2] == 8'(i / 4)) rdata[8*(i % 4) +: 8] = tgt[i];
      if (in_cfg && addr[9:2] == 8'(i / 16)) rdata[2*(i % 16) + 1] = trig_edge[i];
    end
  end
endmodule

module irq_dist_bank_chk #(
  parameter int N_IRQ = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [11:0]      addr,
  input logic [31:0]      wdata,
  input logic [N_IRQ-1:0] irq_in,
  input logic [31:0]      rdata,
  input logic [N_IRQ-1:0] fire,
  input logic [N_IRQ-1:0] en,
  input logic [N_IRQ-1:0] pend_sw,
  input logic [N_IRQ-1:0] in_q
);
  a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h100 && wdata[0]) |=> en[0]);

  a_r2_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h180 && wdata[0]) |=> !en[0]);

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h180 && wdata[0]) |=> !fire[0]);

  a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h280 && wdata[0] && irq_in[0] && !in_q[0]) |=> pend_sw[0]);

  a_r6_sgi_cfg_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 12'hC00) |-> rdata == 32'hAAAA_AAAA);

  a_r10_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[11:10] == 2'b01) |-> rdata == 32'h0);
endmodule

bind irq_dist_bank irq_dist_bank_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq_in(irq_in), .rdata(rdata), .fire(fire), .en(en),
  .pend_sw(pend_sw), .in_q(in_q)
);

// File: tb/irq_dist_bank_tb.sv
module irq_dist_bank_tb;
  localparam int N = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [3:0]    wstrb = '0;
  logic [N-1:0]  irq_in = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  fire;
  logic [8*N-1:0] target_mask;

  int total = 0;
  int bad = 0;
  bit done = 0;

  irq_dist_bank #(.N_IRQ(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wstrb(wstrb), .irq_in(irq_in), .rdata(rdata), .fire(fire),
    .target_mask(target_mask)
  );

  always #5 clk = ~clk;

  bit       m_en [N];
  bit       m_pd [N];
  bit       m_ac [N];
  bit       m_ed [N];
  bit       m_prev [N];
  bit [7:0] m_tg [N];

  function automatic bit m_pend(int n);
    return m_pd[n] || (!m_ed[n] && irq_in[n]);
  endfunction

  always @(posedge clk) begin
    for (int n = 0; n < N; n++) begin
      if (!rst_n) begin
        m_en[n] = 0; m_pd[n] = 0; m_ac[n] = 0; m_prev[n] = 0;
        m_ed[n] = (n < 16); m_tg[n] = 8'h01;
      end else begin
        bit wb;
        int off;
        wb = wdata[n % 32] && wr_en;
        off = int'(addr) - 4 * (n / 32);
        if (wb && off == 'h100) m_en[n] = 1;
        if (wb && off == 'h180) m_en[n] = 0;
        if (wb && off == 'h300) m_ac[n] = 1;
        if (wb && off == 'h380) m_ac[n] = 0;
        if (wb && off == 'h200) m_pd[n] = 1;
        if (wb && off == 'h280) m_pd[n] = 0;
        if (m_ed[n] && irq_in[n] && !m_prev[n]) m_pd[n] = 1;
        if (wr_en && int'(addr) == 'h800 + 4 * (n / 4) && wstrb[n % 4])
          m_tg[n] = wdata[8 * (n % 4) +: 8];
        if (wr_en && n >= 16 && int'(addr) == 'hC00 + 4 * (n / 16))
          m_ed[n] = wdata[2 * (n % 16) + 1];
        m_prev[n] = irq_in[n];
      end
    end
  end

  function automatic logic [31:0] m_read(logic [11:0] a);
    logic [31:0] r;
    int x;
    r = '0;
    x = int'(a);
    for (int n = 0; n < N; n++) begin
      for (int g = 1; g < 8; g++) begin
        if (x == 'h80 * g + 4 * (n / 32) && g >= 2) begin
          if (g / 2 == 1) r[n % 32] = m_en[n];
          if (g / 2 == 2) r[n % 32] = m_pend(n);
          if (g / 2 == 3) r[n % 32] = m_ac[n];
        end
      end
      if (x == 'h800 + 4 * (n / 4)) r[8 * (n % 4) +: 8] = m_tg[n];
      if (x == 'hC00 + 4 * (n / 16)) r[2 * (n % 16) + 1] = m_ed[n];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] ef;
      logic [8*N-1:0] et;
      for (int n = 0; n < N; n++) begin
        ef[n] = m_pend(n) && m_en[n] && !m_ac[n];
        et[8*n +: 8] = m_tg[n];
      end
      chk("R9 fire per cycle", 64'(fire), 64'(ef));
      total++;
      if (target_mask !== et) begin
        bad++;
        $display("FAIL R5 target_mask: actual=%h expected=%h", target_mask, et);
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] s = 4'hF);
    @(negedge clk); #1;
    wr_en = 1; addr = a; wdata = d; wstrb = s;
    @(negedge clk); #1;
    wr_en = 0; wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk); #1;
    addr = a;
    #1;
    chk(tag, 64'(rdata), 64'(exp));
    chk({tag, " model"}, 64'(rdata), 64'(m_read(a)));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(12'h100, 32'h0, "R1 enable reset");
    rd(12'h204, 32'h0, "R1 pending reset");
    rd(12'h300, 32'h0, "R1 active reset");
    rd(12'h82C, 32'h01010101, "R1 target reset");
    rd(12'hC04, 32'h0, "R1 config reset level");
    chk("R1 fire reset", 64'(fire), 64'h0);

    // R2 enable aliases
    wr(12'h100, 32'h0001_0005);
    rd(12'h180, 32'h0001_0005, "R2 enable via clear alias");
    wr(12'h104, 32'h0000_8001);
    rd(12'h104, 32'h0000_8001, "R2 enable word1");
    wr(12'h180, 32'h0000_0001);
    rd(12'h100, 32'h0001_0004, "R2 enable clear bit0");
    wr(12'h100, 32'h0);
    rd(12'h100, 32'h0001_0004, "R2 zero write no effect");

    // R3 pending aliases, R9 fire
    wr(12'h200, 32'h0000_0004);
    rd(12'h280, 32'h0000_0004, "R3 pending via clear alias");
    chk("R9 fire line2", 64'(fire[2]), 64'h1);
    wr(12'h204, 32'h0000_0001);
    rd(12'h204, 32'h0000_0001, "R3 pending word1");
    chk("R9 fire line32", 64'(fire[32]), 64'h1);

    // R4 active blocks fire
    wr(12'h300, 32'h0000_0004);
    rd(12'h380, 32'h0000_0004, "R4 active set");
    chk("R9 active blocks fire", 64'(fire[2]), 64'h0);
    wr(12'h380, 32'h0000_0004);
    rd(12'h300, 32'h0, "R4 active clear");
    chk("R9 fire after active clear", 64'(fire[2]), 64'h1);
    wr(12'h280, 32'h0000_0004);
    rd(12'h200, 32'h0, "R3 pending clear");

    // R5 routing byte lanes
    wr(12'h804, 32'hDEAD_ABCD, 4'b0100);
    rd(12'h804, 32'h01AD_0101, "R5 single lane write");
    chk("R5 target_mask line6", 64'(target_mask[8*6 +: 8]), 64'hAD);
    wr(12'h804, 32'h1122_3344, 4'b1001);
    rd(12'h804, 32'h11AD_0144, "R5 two lanes write");

    // R6 configuration
    wr(12'hC00, 32'h0000_0000);
    rd(12'hC00, 32'hAAAA_AAAA, "R6 fixed range ignores writes");
    wr(12'hC04, 32'hFFFF_00AA);
    rd(12'hC04, 32'hAAAA_00AA, "R6 config readback");

    // R7 edge lines 16 and 17
    @(negedge clk); #1; irq_in[16] = 1;
    @(negedge clk); #1; irq_in[16] = 0;
    rd(12'h200, 32'h0001_0000, "R7 rising edge sets pending");
    chk("R9 edge fire line16", 64'(fire[16]), 64'h1);
    wr(12'h200, 32'h0002_0000);
    @(negedge clk); #1;
    irq_in[17] = 1; wr_en = 1; addr = 12'h280; wdata = 32'h0002_0000; wstrb = 4'hF;
    @(negedge clk); #1; wr_en = 0; wdata = '0;
    rd(12'h200, 32'h0003_0000, "R7 edge beats same-cycle clear");
    wr(12'h280, 32'h0002_0000);
    rd(12'h200, 32'h0001_0000, "R7 held input makes no new edge");
    irq_in[17] = 0;

    // R8 level line 20 and 40
    @(negedge clk); #1; irq_in[20] = 1; irq_in[40] = 1;
    rd(12'h200, 32'h0011_0000, "R8 level follows input");
    rd(12'h204, 32'h0000_0101, "R8 level word1");
    wr(12'h280, 32'h0010_0000);
    rd(12'h200, 32'h0011_0000, "R8 clear cannot hide level");
    @(negedge clk); #1; irq_in[20] = 0;
    rd(12'h200, 32'h0001_0000, "R8 level drop clears pending");

    // R10 unimplemented bits and holes
    wr(12'h104, 32'hFFFF_FFFF);
    rd(12'h104, 32'h0000_FFFF, "R10 upper bits of partial word");
    rd(12'h108, 32'h0, "R10 word beyond lines");
    wr(12'h830, 32'hFFFF_FFFF);
    rd(12'h830, 32'h0, "R10 target beyond lines");
    rd(12'hC0C, 32'h0, "R10 config beyond lines");
    wr(12'h400, 32'hFFFF_FFFF);
    rd(12'h400, 32'h0, "R10 hole reads zero");
    rd(12'h000, 32'h0, "R10 low hole reads zero");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule